// File: doc/BRIEF.md
# Handshaked Operand Stage with Accumulating Add/Subtract

This block takes operand words from an upstream producer over a valid/ready handshake. Its ready output works like a bus acknowledge. It answers a request that is already pending, rather than announcing free space, so it is never high while valid is low. Each new request first passes through a set number of wait states (parameter `WAIT_CYCLES`). After that, ready is raised and the word, together with its add/subtract select, is latched on that transfer cycle.

Each latched operand drives an accumulator. The accumulator adds the operand to its running value or subtracts it, modulo 2^`DATA_W`. The new value appears with a one-cycle valid pulse. Transfers may run back to back. With `WAIT_CYCLES` = 0 one word moves every cycle while valid stays high. With a non-zero setting every word, including one that follows a transfer directly, sees the full wait again.

Top module: `opnd_ack_stage`

## Requirements
- R1: While `rst_ni` is low, `ready_o` is 0, `result_o` is 0 and `result_valid_o` is 0, even if `valid_i` is high. After release, `valid_i` is first driven high no earlier than the second clock.
- R2: `ready_o` is 0 in every cycle in which `valid_i` is 0.
- R3: When `valid_i` is held high for a new request, `ready_o` stays 0 for exactly `WAIT_CYCLES` cycles (wait states) and is 1 in the following cycle.
- R4: A cycle with `valid_i` and `ready_o` both 1 at a rising clock edge is exactly one transfer. It latches `data_i` and `sub_i` once.
- R5: After a transfer the wait count starts again. If `valid_i` stays high, the next word again waits `WAIT_CYCLES` cycles. With `WAIT_CYCLES` = 0, every cycle with `valid_i` high is a transfer.
- R6: For the transfer at edge E, `result_o` after edge E+1 equals the previous `result_o` plus the operand when `sub_i` = 0. When `sub_i` = 1 it equals the previous `result_o` minus the operand. Both wrap modulo 2^`DATA_W`.
- R7: `result_valid_o` is 1 for exactly the one cycle after edge E+1 for each transfer at edge E, and 0 in all other cycles.
- R8: If `valid_i` falls before `ready_o` was given, no transfer happens. The next request starts a full wait of `WAIT_CYCLES` cycles.
- R9: `result_o` changes only at an edge that also raises `result_valid_o`. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Operand word, held stable through wait states |
| sub_i | input | 1 | 0 = add operand, 1 = subtract operand |
| valid_i | input | 1 | Request pending |
| ready_o | output | 1 | Acknowledge; transfer when high together with valid_i |
| result_o | output | DATA_W | Accumulated result |
| result_valid_o | output | 1 | One-cycle pulse per new result |

## Verification
A wrong wait counter shows up at the ports within the same request. Ready comes early or late against the count of valid-high cycles, or it shows up with valid low. The bench tracks this cycle by cycle.

A lost or repeated capture, or a wrong add/subtract select, changes `result_o` two edges after the transfer. Because the result accumulates, the error then stays visible in every later comparison. A stray result pulse or a result that drifts is caught in the first cycle it occurs.

// File: rtl/opnd_ack_pkg.sv
package opnd_ack_pkg;
  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_op_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val > 0) ? $clog2(max_val + 1) : 1;
  endfunction
endpackage

// File: rtl/opnd_wait_ctl.sv
module opnd_wait_ctl #(
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic ready_o
);
  import opnd_ack_pkg::*;

  localparam int unsigned CNT_W = cnt_width(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] WAIT_L = CNT_W'(WAIT_CYCLES);

  generate
    if (WAIT_CYCLES == 0) begin : g_nowait
      // one-cycle arm after reset keeps ack low without a comb reset path
      logic live_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= 1'b1;
      end
      assign ready_o = valid_i & live_q;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      assign ready_o = valid_i && (cnt_q == WAIT_L);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 cnt_q <= '0;
        else if (!valid_i || ready_o) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/opnd_capture.sv
module opnd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    xfer_i,
  input  logic [DATA_W-1:0]       data_i,
  input  opnd_ack_pkg::alu_op_e   op_i,
  output logic [DATA_W-1:0]       opnd_o,
  output opnd_ack_pkg::alu_op_e   op_o,
  output logic                    vld_o
);
  import opnd_ack_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_o <= '0;
      op_o   <= ALU_ADD;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= xfer_i;
      if (xfer_i) begin
        opnd_o <= data_i;
        op_o   <= op_i;
      end
    end
  end
endmodule

// File: rtl/opnd_alu.sv
module opnd_alu #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic [DATA_W-1:0]     opnd_i,
  input  opnd_ack_pkg::alu_op_e op_i,
  output logic [DATA_W-1:0]     res_o,
  output logic                  res_vld_o
);
  import opnd_ack_pkg::*;

  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (op_i)
      ALU_SUB: nxt = res_o - opnd_i;
      default: nxt = res_o + opnd_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= vld_i;
      if (vld_i) res_o <= nxt;
    end
  end
endmodule

// File: rtl/opnd_ack_stage.sv
module opnd_ack_stage #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sub_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);
  import opnd_ack_pkg::*;

  logic              xfer;
  logic [DATA_W-1:0] cap_opnd;
  alu_op_e           cap_op;
  alu_op_e           in_op;
  logic              cap_vld;

  assign in_op = sub_i ? ALU_SUB : ALU_ADD;
  assign xfer  = valid_i & ready_o;

  opnd_wait_ctl #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ready_o (ready_o)
  );

  opnd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .xfer_i (xfer),
    .data_i (data_i),
    .op_i   (in_op),
    .opnd_o (cap_opnd),
    .op_o   (cap_op),
    .vld_o  (cap_vld)
  );

  opnd_alu #(.DATA_W(DATA_W)) u_alu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (cap_vld),
    .opnd_i    (cap_opnd),
    .op_i      (cap_op),
    .res_o     (result_o),
    .res_vld_o (result_valid_o)
  );
endmodule

// File: rtl/opnd_ack_stage_chk.sv
module opnd_ack_stage_chk #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              sub_i,
  input logic              valid_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] result_o,
  input logic              result_valid_o
);
  import opnd_ack_pkg::*;

  localparam int unsigned CNT_W = cnt_width(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] WAIT_L = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0]  run_q;
  logic              armed_q;
  logic              x1_q, x2_q, s1_q, s2_q;
  logic [DATA_W-1:0] d1_q, d2_q;
  logic              xfer;

  assign xfer = valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0; armed_q <= 1'b0;
      x1_q <= 1'b0; x2_q <= 1'b0; s1_q <= 1'b0; s2_q <= 1'b0;
      d1_q <= '0; d2_q <= '0;
    end else begin
      armed_q <= 1'b1;
      if (!valid_i || ready_o) run_q <= '0;
      else if (run_q != WAIT_L) run_q <= run_q + 1'b1;
      x1_q <= xfer; x2_q <= x1_q;
      s1_q <= sub_i; s2_q <= s1_q;
      d1_q <= data_i; d2_q <= d1_q;
    end
  end

  p_ready_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !ready_o);

  p_ready_after_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && valid_i && run_q == WAIT_L) |-> ready_o);

  p_no_early_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && run_q != WAIT_L) |-> !ready_o);

  p_one_pulse_per_xfer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o == x2_q);

  p_result_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> result_o == (s2_q ? $past(result_o) - d2_q
                                         : $past(result_o) + d2_q));

  p_result_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != $past(result_o)) |-> result_valid_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!ready_o && !result_valid_o && result_o == '0);
    end
  end
endmodule

bind opnd_ack_stage opnd_ack_stage_chk #(
  .DATA_W(DATA_W), .WAIT_CYCLES(WAIT_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .sub_i(sub_i),
  .valid_i(valid_i), .ready_o(ready_o), .result_o(result_o),
  .result_valid_o(result_valid_o)
);

// File: tb/opnd_ack_stage_test.sv
module opnd_ack_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int WAITS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] data = '0, res;
  logic sub = 1'b0, valid = 1'b0, ready, res_vld;
  logic [DW-1:0] dz = '0, resz;
  logic sz = 1'b0, vz = 1'b0, rz, rvz;

  opnd_ack_stage #(.DATA_W(DW), .WAIT_CYCLES(WAITS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .sub_i(sub), .valid_i(valid),
    .ready_o(ready), .result_o(res), .result_valid_o(res_vld));

  opnd_ack_stage #(.DATA_W(DW), .WAIT_CYCLES(0)) uut_z (
    .clk_i(clk), .rst_ni(rst_n), .data_i(dz), .sub_i(sz), .valid_i(vz),
    .ready_o(rz), .result_o(resz), .result_valid_o(rvz));

  int n_chk = 0, n_fail = 0;
  string tag = "R3";
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model for the main instance, sampled at falling edges
  int run = 0;
  bit x1 = 0, x2 = 0, s1 = 0, s2 = 0;
  logic [DW-1:0] d1 = '0, d2 = '0, acc = '0;
  always @(negedge clk) begin
    if (mon_en) begin
      bit exp_rdy;
      exp_rdy = valid && (run == WAITS);
      chk(ready == exp_rdy, valid ? tag : "R2", "ready_o", 32'(ready), 32'(exp_rdy));
      chk(res_vld == x2, x2 ? "R4" : "R7", "result_valid_o", 32'(res_vld), 32'(x2));
      if (x2) acc = s2 ? acc - d2 : acc + d2;
      chk(res == acc, x2 ? "R6" : "R9", "result_o", 32'(res), 32'(acc));
      x2 = x1; d2 = d1; s2 = s1;
      x1 = valid && ready; d1 = data; s1 = sub;
      if (!valid || ready) run = 0; else run++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [DW-1:0] d, input logic s);
    data = d; sub = s; valid = 1'b1;
    do @(negedge clk); while (!ready);
    tick();
  endtask

  task automatic idle(input int n);
    valid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic run_all();
    // R1: reset with requests pending on both instances
    valid = 1'b1; vz = 1'b1; data = 16'h1234; dz = 16'h4321;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1", "ready_o in reset", 32'(ready), 0);
    chk(rz == 1'b0, "R1", "zero-wait ready_o in reset", 32'(rz), 0);
    chk(res == '0 && res_vld == 1'b0, "R1", "result in reset", 32'(res), 0);
    chk(resz == '0 && rvz == 1'b0, "R1", "zero-wait result in reset", 32'(resz), 0);
    valid = 1'b0; vz = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    tick(); tick();
    mon_en = 1'b1;

    tag = "R3"; send(16'h0010, 1'b0); idle(2);
    tag = "R5"; send(16'h0003, 1'b0); send(16'h0005, 1'b0); send(16'h0002, 1'b1); idle(1);
    tag = "R8"; valid = 1'b1; data = 16'h0777; tick(); idle(2);
    send(16'h0001, 1'b0); idle(1);
    tag = "R6"; send(16'h0100, 1'b1); idle(3);

    for (int i = 0; i < 400; i++) begin
      logic [DW-1:0] d = DW'($urandom);
      logic s = 1'($urandom);
      if ($urandom % 8 == 0) begin
        tag = "R8"; valid = 1'b1; data = d; tick(); idle(1 + $urandom % 2);
      end
      tag = "R3";
      send(d, s);
      if ($urandom % 3 != 0) begin
        tag = "R5";
      end else begin
        idle($urandom % 3);
      end
    end
    idle(4);
    mon_en = 1'b0;

    // zero-wait variant: one transfer per cycle
    tick();
    vz = 1'b1; dz = 16'h0011; sz = 1'b0;
    @(negedge clk); chk(rz == 1'b1, "R5", "zero-wait ready word A", 32'(rz), 1);
    chk(rvz == 1'b0, "R7", "zero-wait no early pulse", 32'(rvz), 0);
    tick(); dz = 16'h0022;
    @(negedge clk); chk(rz == 1'b1, "R5", "zero-wait ready word B", 32'(rz), 1);
    tick(); dz = 16'h0040; sz = 1'b1;
    @(negedge clk); chk(rz == 1'b1, "R5", "zero-wait ready word C", 32'(rz), 1);
    chk(rvz == 1'b1 && resz == 16'h0011, "R6", "zero-wait result A", 32'(resz), 32'h11);
    tick(); vz = 1'b0; sz = 1'b0;
    @(negedge clk); chk(rz == 1'b0, "R2", "zero-wait ready with valid low", 32'(rz), 0);
    chk(rvz == 1'b1 && resz == 16'h0033, "R6", "zero-wait result A+B", 32'(resz), 32'h33);
    @(negedge clk);
    chk(rvz == 1'b1 && resz == 16'hfff3, "R6", "zero-wait result wraps", 32'(resz), 32'hfff3);
    @(negedge clk);
    chk(rvz == 1'b0, "R7", "zero-wait pulse ends", 32'(rvz), 0);
    chk(resz == 16'hfff3, "R9", "zero-wait result holds", 32'(resz), 32'hfff3);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a11));
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule